// File: doc/BRIEF.md
# Control-Transfer Target and Alignment Unit

This combinational unit resolves jumps and conditional branches for a 32- or 64-bit integer core. Each cycle it receives one decoded control-transfer operation, the current PC, the sequential next PC, two register operands, an immediate that is already sign-extended, and a destination register index. From these it forms the target address and decides whether the transfer is taken. It then either steers the next PC to the target or flags an instruction-address-misaligned fault.

The alignment check depends on a runtime input that says whether 16-bit instructions are supported. When they are supported, any even target is legal. When they are not, a taken target with address bit 1 set raises the fault. A raised fault suppresses both the link write and the redirect, so the trap logic downstream sees an architecturally clean instruction. Not-taken branches are never checked. The link value is always the incoming sequential next PC, so one path serves both the 2-byte and the 4-byte instruction forms.

Top module: `ctu_xfer_unit`

## Requirements
- R1: For operation code 0 (direct jump), the target is pc plus imm. When there is no fault, next_pc_o equals that target and redirect_o is 1.
- R2: For operation code 1 (register jump), the target is rs1 plus imm with bit 0 of the sum cleared. The alignment check is applied to this cleared value.
- R3: Codes 2 to 7 are conditional branches with target pc plus imm: 2 taken when equal, 3 when not equal, 4 when rs1 < rs2 signed, 5 when rs1 >= rs2 signed, 6 when rs1 < rs2 unsigned, 7 when rs1 >= rs2 unsigned. taken_o reports the outcome.
- R4: A branch that is not taken gives redirect_o = 0, misalign_o = 0 and next_pc_o = seq_pc_i, whatever its target bits are.
- R5: A taken transfer whose target has bit 1 set while c_ext_en_i = 0 sets misalign_o = 1 and puts the target on fault_addr_o. At all other times fault_addr_o is 0.
- R6: While misalign_o is 1, rd_we_o is 0, redirect_o is 0 and next_pc_o equals seq_pc_i.
- R7: With c_ext_en_i = 1, a taken target with bit 1 set is redirected and raises no fault.
- R8: For both jump codes, when there is no fault and rd_idx_i is non-zero, rd_we_o is 1, rd_idx_o equals rd_idx_i, and rd_data_o equals seq_pc_i. The target uses the incoming rs1 value even when the destination is the same register.
- R9: rd_we_o is never 1 when the destination index is 0.
- R10: When xfer_valid_i is 0, taken_o, redirect_o, rd_we_o and misalign_o are all 0 and next_pc_o equals seq_pc_i.
- R11: For every taken transfer, exactly one of redirect_o and misalign_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xfer_valid_i | input | 1 | A control-transfer operation is present |
| xfer_op_i | input | 3 | Operation code (0 direct jump, 1 register jump, 2..7 branches as in R3) |
| pc_i | input | XLEN | Address of the current instruction |
| seq_pc_i | input | XLEN | Sequential next PC (pc+2 or pc+4) |
| rs1_val_i | input | XLEN | First source operand |
| rs2_val_i | input | XLEN | Second source operand |
| imm_i | input | XLEN | Sign-extended immediate |
| rd_idx_i | input | RIDX_W | Destination register index |
| c_ext_en_i | input | 1 | 16-bit instructions supported |
| next_pc_o | output | XLEN | Next fetch address |
| redirect_o | output | 1 | next_pc_o differs from the sequential path |
| taken_o | output | 1 | Transfer taken (jumps always, branches by condition) |
| rd_we_o | output | 1 | Link register write enable |
| rd_idx_o | output | RIDX_W | Link register index |
| rd_data_o | output | XLEN | Link value |
| misalign_o | output | 1 | Instruction-address-misaligned fault |
| fault_addr_o | output | XLEN | Faulting target address, 0 when no fault |

## Verification
The unit holds no state, so any internal fault appears at the ports in the same cycle as the operation that exposes it. A wrong comparator result shows up as a flipped taken_o and a next_pc_o that follows the wrong path. A broken alignment gate shows up as a missing fault, or as a fault together with a link write or a redirect. A wrong adder input, such as pc used where rs1 belongs, shows up directly on next_pc_o or fault_addr_o. Directed cases therefore pair each operation code with targets on both sides of bit 1, with both settings of the 16-bit enable, and with operands on both sides of the signed/unsigned boundary.

// File: rtl/ctu_pkg.sv
package ctu_pkg;

   typedef enum logic [2:0] {
      OP_JMP_DIR = 3'd0,
      OP_JMP_REG = 3'd1,
      OP_BR_EQ   = 3'd2,
      OP_BR_NE   = 3'd3,
      OP_BR_LT   = 3'd4,
      OP_BR_GE   = 3'd5,
      OP_BR_LTU  = 3'd6,
      OP_BR_GEU  = 3'd7
   } xfer_op_e;

   // Comparator implementation choices
   localparam int CMP_OPERATORS  = 0;
   localparam int CMP_SUBTRACTOR = 1;

   function automatic logic op_is_jump(input xfer_op_e op);
      return (op == OP_JMP_DIR) || (op == OP_JMP_REG);
   endfunction

   function automatic logic op_uses_rs1_base(input xfer_op_e op);
      return op == OP_JMP_REG;
   endfunction

endpackage

// File: rtl/ctu_target_gen.sv
module ctu_target_gen
   import ctu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  xfer_op_e          op_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   rs1_i,
   input  logic [XLEN-1:0]   imm_i,
   output logic [XLEN-1:0]   target_o
);

   localparam int LSB_W = 1;

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] sum;
   logic            reg_form;

   always_comb begin
      reg_form = op_uses_rs1_base(op_i);
      base     = reg_form ? rs1_i : pc_i;
      sum      = base + imm_i;
   end

   // Register-form target has its lowest bit forced to zero before any check
   always_comb begin
      target_o = sum;
      if (reg_form) begin
         target_o[LSB_W-1:0] = '0;
      end
   end

endmodule

// File: rtl/ctu_branch_cmp.sv
module ctu_branch_cmp
   import ctu_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int CMP_STYLE = CMP_SUBTRACTOR
) (
   input  xfer_op_e          op_i,
   input  logic [XLEN-1:0]   a_i,
   input  logic [XLEN-1:0]   b_i,
   output logic              cond_o
);

   localparam int MSB = XLEN - 1;

   logic eq;
   logic lt_s;
   logic lt_u;

   assign eq = (a_i == b_i);

   generate
      if (CMP_STYLE == CMP_SUBTRACTOR) begin : g_sub
         logic [XLEN:0] diff;
         logic          borrow;
         always_comb begin
            diff   = {1'b0, a_i} - {1'b0, b_i};
            borrow = diff[XLEN];
            lt_u   = borrow;
            // Differing signs decide directly; equal signs fall back to the borrow
            lt_s   = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : borrow;
         end
      end else begin : g_ops
         always_comb begin
            lt_u = a_i < b_i;
            lt_s = $signed(a_i) < $signed(b_i);
         end
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_BR_EQ:  cond_o = eq;
         OP_BR_NE:  cond_o = !eq;
         OP_BR_LT:  cond_o = lt_s;
         OP_BR_GE:  cond_o = !lt_s;
         OP_BR_LTU: cond_o = lt_u;
         OP_BR_GEU: cond_o = !lt_u;
         default:   cond_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/ctu_align_chk.sv
module ctu_align_chk #(
   parameter int XLEN        = 64,
   parameter bit ZERO_NOFLT  = 1'b1
) (
   input  logic              check_en_i,
   input  logic              c_ext_en_i,
   input  logic [XLEN-1:0]   target_i,
   output logic              misalign_o,
   output logic [XLEN-1:0]   fault_addr_o
);

   localparam int HALF_BIT = 1;

   // Bit 1 set means the target is only 2-byte aligned
   assign misalign_o = check_en_i && !c_ext_en_i && target_i[HALF_BIT];

   generate
      if (ZERO_NOFLT) begin : g_zero
         assign fault_addr_o = misalign_o ? target_i : '0;
      end else begin : g_pass
         assign fault_addr_o = target_i;
      end
   endgenerate

endmodule

// File: rtl/ctu_xfer_unit.sv
module ctu_xfer_unit
   import ctu_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int RIDX_W    = 5,
   parameter int CMP_STYLE = CMP_SUBTRACTOR
) (
   input  logic              xfer_valid_i,
   input  logic [2:0]        xfer_op_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   seq_pc_i,
   input  logic [XLEN-1:0]   rs1_val_i,
   input  logic [XLEN-1:0]   rs2_val_i,
   input  logic [XLEN-1:0]   imm_i,
   input  logic [RIDX_W-1:0] rd_idx_i,
   input  logic              c_ext_en_i,
   output logic [XLEN-1:0]   next_pc_o,
   output logic              redirect_o,
   output logic              taken_o,
   output logic              rd_we_o,
   output logic [RIDX_W-1:0] rd_idx_o,
   output logic [XLEN-1:0]   rd_data_o,
   output logic              misalign_o,
   output logic [XLEN-1:0]   fault_addr_o
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("ctu_xfer_unit: XLEN must be 32 or 64");
      end
      if (RIDX_W < 1 || RIDX_W > 6) begin : g_bad_ridx
         $error("ctu_xfer_unit: RIDX_W out of range");
      end
      if (CMP_STYLE != CMP_OPERATORS && CMP_STYLE != CMP_SUBTRACTOR) begin : g_bad_cmp
         $error("ctu_xfer_unit: unknown CMP_STYLE");
      end
   endgenerate

   xfer_op_e        op;
   logic            is_jump;
   logic            cond_true;
   logic [XLEN-1:0] target;
   logic            fault;
   logic            go;

   assign op      = xfer_op_e'(xfer_op_i);
   assign is_jump = op_is_jump(op);

   ctu_target_gen #(.XLEN(XLEN)) u_tgt (
      .op_i     (op),
      .pc_i     (pc_i),
      .rs1_i    (rs1_val_i),
      .imm_i    (imm_i),
      .target_o (target)
   );

   ctu_branch_cmp #(.XLEN(XLEN), .CMP_STYLE(CMP_STYLE)) u_cmp (
      .op_i   (op),
      .a_i    (rs1_val_i),
      .b_i    (rs2_val_i),
      .cond_o (cond_true)
   );

   ctu_align_chk #(.XLEN(XLEN), .ZERO_NOFLT(1'b1)) u_aln (
      .check_en_i   (taken_o),
      .c_ext_en_i   (c_ext_en_i),
      .target_i     (target),
      .misalign_o   (fault),
      .fault_addr_o (fault_addr_o)
   );

   always_comb begin
      taken_o    = xfer_valid_i && (is_jump || cond_true);
      misalign_o = fault;
      go         = taken_o && !fault;
      redirect_o = go;
      next_pc_o  = go ? target : seq_pc_i;
      // Link value comes from the incoming sequential PC, before any rd update
      rd_data_o  = seq_pc_i;
      rd_idx_o   = rd_idx_i;
      rd_we_o    = go && is_jump && (rd_idx_i != '0);
   end

endmodule

// File: rtl/ctu_xfer_chk.sv
module ctu_xfer_chk #(
   parameter int XLEN   = 64,
   parameter int RIDX_W = 5
) (
   input logic              valid,
   input logic [2:0]        op,
   input logic [XLEN-1:0]   seq_pc,
   input logic [RIDX_W-1:0] rd_in,
   input logic              c_ext,
   input logic [XLEN-1:0]   next_pc,
   input logic              redirect,
   input logic              taken,
   input logic              rd_we,
   input logic [XLEN-1:0]   rd_data,
   input logic              misalign,
   input logic [XLEN-1:0]   fault_addr
);

   always_comb begin
      assert_no_x0_write_R9: assert (!(rd_we && rd_in == '0))
         else $error("write to index 0");
      assert_fault_blocks_R6: assert (!misalign || (!rd_we && !redirect && next_pc == seq_pc))
         else $error("fault did not suppress write or redirect");
      assert_fault_cause_R5: assert (!misalign || (!c_ext && fault_addr[1] && taken))
         else $error("fault without cause");
      assert_fault_addr_quiet_R5: assert (misalign || fault_addr == '0)
         else $error("fault address without fault");
      assert_cext_no_fault_R7: assert (!c_ext || !misalign)
         else $error("fault with 16-bit support on");
      assert_one_outcome_R11: assert (!taken || (redirect ^ misalign))
         else $error("taken transfer outcome not exclusive");
      assert_not_taken_quiet_R4: assert (taken || (!redirect && !misalign && next_pc == seq_pc))
         else $error("not-taken transfer changed flow");
      assert_reg_jump_even_R2: assert (!(valid && op == 3'd1 && redirect) || !next_pc[0])
         else $error("register jump target odd");
      assert_link_value_R8: assert (!rd_we || rd_data == seq_pc)
         else $error("link value wrong");
      assert_idle_R10: assert (valid || (!taken && !rd_we && !redirect))
         else $error("activity while idle");
   end

endmodule

bind ctu_xfer_unit ctu_xfer_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
   .valid      (xfer_valid_i),
   .op         (xfer_op_i),
   .seq_pc     (seq_pc_i),
   .rd_in      (rd_idx_i),
   .c_ext      (c_ext_en_i),
   .next_pc    (next_pc_o),
   .redirect   (redirect_o),
   .taken      (taken_o),
   .rd_we      (rd_we_o),
   .rd_data    (rd_data_o),
   .misalign   (misalign_o),
   .fault_addr (fault_addr_o)
);

// File: tb/ctu_xfer_unit_tb.sv
module ctu_xfer_unit_tb;

   localparam int XLEN   = 64;
   localparam int RIDX_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5ns clk = ~clk;

   logic              xfer_valid_i = 1'b0;
   logic [2:0]        xfer_op_i = '0;
   logic [XLEN-1:0]   pc_i = '0, seq_pc_i = '0, rs1_val_i = '0, rs2_val_i = '0, imm_i = '0;
   logic [RIDX_W-1:0] rd_idx_i = '0;
   logic              c_ext_en_i = 1'b0;
   logic [XLEN-1:0]   next_pc_o, rd_data_o, fault_addr_o;
   logic              redirect_o, taken_o, rd_we_o, misalign_o;
   logic [RIDX_W-1:0] rd_idx_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   ctu_xfer_unit #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_dut (
      .xfer_valid_i (xfer_valid_i), .xfer_op_i (xfer_op_i), .pc_i (pc_i),
      .seq_pc_i (seq_pc_i), .rs1_val_i (rs1_val_i), .rs2_val_i (rs2_val_i),
      .imm_i (imm_i), .rd_idx_i (rd_idx_i), .c_ext_en_i (c_ext_en_i),
      .next_pc_o (next_pc_o), .redirect_o (redirect_o), .taken_o (taken_o),
      .rd_we_o (rd_we_o), .rd_idx_o (rd_idx_o), .rd_data_o (rd_data_o),
      .misalign_o (misalign_o), .fault_addr_o (fault_addr_o)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Drive one operation and compare every output against a model built from the requirements
   task automatic apply(input bit v, input logic [2:0] op, input logic [XLEN-1:0] pc,
                        input logic [XLEN-1:0] seq, input logic [XLEN-1:0] a,
                        input logic [XLEN-1:0] b, input logic [XLEN-1:0] imm,
                        input logic [RIDX_W-1:0] rd, input bit cx, input string tag);
      logic [XLEN-1:0] tgt, e_next, e_fa;
      bit cond, e_tk, e_mis, e_red, e_we, jmp;
      @(posedge clk);
      xfer_valid_i = v; xfer_op_i = op; pc_i = pc; seq_pc_i = seq;
      rs1_val_i = a; rs2_val_i = b; imm_i = imm; rd_idx_i = rd; c_ext_en_i = cx;
      @(negedge clk);
      jmp = (op == 3'd0) || (op == 3'd1);
      tgt = (op == 3'd1) ? ((a + imm) & ~64'd1) : (pc + imm);
      case (op)
         3'd2: cond = (a == b);
         3'd3: cond = (a != b);
         3'd4: cond = ($signed(a) < $signed(b));
         3'd5: cond = ($signed(a) >= $signed(b));
         3'd6: cond = (a < b);
         3'd7: cond = (a >= b);
         default: cond = 1'b1;
      endcase
      e_tk   = v && cond;
      e_mis  = e_tk && tgt[1] && !cx;
      e_red  = e_tk && !e_mis;
      e_next = e_red ? tgt : seq;
      e_we   = e_red && jmp && (rd != 0);
      e_fa   = e_mis ? tgt : '0;
      chk(taken_o == e_tk, tag, "taken", 64'(taken_o), 64'(e_tk));
      chk(misalign_o == e_mis, tag, "misalign", 64'(misalign_o), 64'(e_mis));
      chk(redirect_o == e_red, tag, "redirect", 64'(redirect_o), 64'(e_red));
      chk(next_pc_o == e_next, tag, "next_pc", next_pc_o, e_next);
      chk(fault_addr_o == e_fa, tag, "fault_addr", fault_addr_o, e_fa);
      chk(rd_we_o == e_we, tag, "rd_we", 64'(rd_we_o), 64'(e_we));
      if (e_we) begin
         chk(rd_data_o == seq, tag, "rd_data", rd_data_o, seq);
         chk(rd_idx_o == rd, tag, "rd_idx", 64'(rd_idx_o), 64'(rd));
      end
      if (e_tk) chk((redirect_o ^ misalign_o) == 1'b1, "R11", "one outcome",
                    64'({redirect_o, misalign_o}), 64'(e_red ? 2 : 1));
   endtask

   task automatic t_reset;   // R10
      @(negedge clk);
      chk(!taken_o && !redirect_o && !rd_we_o && !misalign_o, "R10", "reset idle",
          64'({taken_o, redirect_o, rd_we_o, misalign_o}), 64'd0);
      apply(1'b0, 3'd0, 64'h1000, 64'h1004, 64'h0, 64'h0, 64'h6, 5'd1, 1'b0, "R10");
   endtask

   task automatic t_direct_jump;   // R1 R8
      apply(1'b1, 3'd0, 64'h1000, 64'h1004, 64'h0, 64'h0, -64'sd8, 5'd1, 1'b0, "R1");
      apply(1'b1, 3'd0, 64'h8000_0000, 64'h8000_0002, 64'h0, 64'h0, 64'h400, 5'd31, 1'b1, "R8");
   endtask

   task automatic t_register_jump;   // R2 R8
      apply(1'b1, 3'd1, 64'h0, 64'h504, 64'h3001, 64'h0, 64'h3, 5'd5, 1'b0, "R2");
      apply(1'b1, 3'd1, 64'h0, 64'h504, 64'h2003, 64'h0, 64'h10, 5'd5, 1'b1, "R2");
      apply(1'b1, 3'd1, 64'h0, 64'h77c, 64'h4000, 64'h0, -64'sd4, 5'd7, 1'b0, "R8");
   endtask

   task automatic t_branches;   // R3
      apply(1'b1, 3'd2, 64'h100, 64'h104, 64'd9, 64'd9, 64'h20, 5'd0, 1'b0, "R3");
      apply(1'b1, 3'd3, 64'h100, 64'h104, 64'd9, 64'd9, 64'h20, 5'd0, 1'b0, "R3");
      apply(1'b1, 3'd3, 64'h100, 64'h104, 64'd9, 64'd8, 64'h20, 5'd0, 1'b0, "R3");
      apply(1'b1, 3'd4, 64'h100, 64'h104, -64'sd1, 64'd1, 64'h40, 5'd0, 1'b0, "R3");
      apply(1'b1, 3'd5, 64'h100, 64'h104, -64'sd1, 64'd1, 64'h40, 5'd0, 1'b0, "R3");
      apply(1'b1, 3'd6, 64'h100, 64'h104, -64'sd1, 64'd1, 64'h40, 5'd0, 1'b0, "R3");
      apply(1'b1, 3'd7, 64'h100, 64'h104, -64'sd1, 64'd1, 64'h40, 5'd0, 1'b0, "R3");
      apply(1'b1, 3'd5, 64'h100, 64'h104, 64'd5, 64'd5, -64'sd16, 5'd0, 1'b0, "R3");
      apply(1'b1, 3'd7, 64'h100, 64'h104, 64'd3, 64'd4, -64'sd16, 5'd0, 1'b0, "R3");
   endtask

   task automatic t_not_taken_unchecked;   // R4
      apply(1'b1, 3'd2, 64'h200, 64'h204, 64'd1, 64'd2, 64'h6, 5'd0, 1'b0, "R4");
      apply(1'b1, 3'd6, 64'h200, 64'h204, 64'd9, 64'd2, -64'sd2, 5'd0, 1'b0, "R4");
   endtask

   task automatic t_misaligned;   // R5 R6
      apply(1'b1, 3'd0, 64'h1000, 64'h1004, 64'h0, 64'h0, 64'h6, 5'd1, 1'b0, "R5");
      apply(1'b1, 3'd3, 64'h1000, 64'h1004, 64'd1, 64'd2, -64'sd2, 5'd0, 1'b0, "R5");
      apply(1'b1, 3'd1, 64'h0, 64'h904, 64'h2003, 64'h0, 64'h10, 5'd5, 1'b0, "R6");
      apply(1'b1, 3'd0, 64'h40, 64'h44, 64'h0, 64'h0, 64'h2, 5'd3, 1'b0, "R6");
   endtask

   task automatic t_compressed_ok;   // R7
      apply(1'b1, 3'd0, 64'h1000, 64'h1002, 64'h0, 64'h0, 64'h6, 5'd1, 1'b1, "R7");
      apply(1'b1, 3'd4, 64'h1000, 64'h1002, 64'd1, 64'd2, 64'h22, 5'd0, 1'b1, "R7");
   endtask

   task automatic t_rd_zero;   // R9
      apply(1'b1, 3'd0, 64'h1000, 64'h1004, 64'h0, 64'h0, 64'h100, 5'd0, 1'b0, "R9");
      apply(1'b1, 3'd1, 64'h0, 64'h1004, 64'h3000, 64'h0, 64'h0, 5'd0, 1'b0, "R9");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_direct_jump();
      t_register_jump();
      t_branches();
      t_not_taken_unchecked();
      t_misaligned();
      t_compressed_ok();
      t_rd_zero();
      apply(1'b0, 3'd3, 64'h200, 64'h204, 64'd1, 64'd2, 64'h6, 5'd4, 1'b0, "R10");
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule